// File: doc/BRIEF.md
# Write-Only Configuration Register Target on a Two-Wire Serial Bus

This block is a bus target that takes configuration writes for a bank of eight 8-bit control registers. A typical use is holding the gain, tone and attenuator settings of a multi-stage audio path. A fast system clock oversamples the serial clock line and the serial data line. The block detects bus start and stop conditions and checks the first byte against a fixed 7-bit device address with the write direction bit. It then reads a register-selection byte and stores every data byte that follows.

The selection byte holds a 4-bit register pointer and a mode flag. With the flag clear, every data byte in the transfer overwrites the same register. With the flag set, the pointer advances after each data byte. Pointer values outside the bank are legal on the bus, but writes to them are discarded. The block acknowledges by pulling the data line low through an open-drain style output. All registers are presented in parallel.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register output reads 0x00 and the data-line pull output is inactive (0).
- R2: A STOP (data rising while clock high) returns the block to idle. Bytes clocked afterwards without a new START get no acknowledge and change no register.
- R3: The first byte after a START must equal 0x88 (device address 1000100 followed by write bit 0) to be acknowledged. Any other first byte, including 0x89, gets no acknowledge, and the rest of that transfer is ignored until the next START.
- R4: The block holds the data line low during the ninth clock of the address byte, the selection byte and every data byte it accepts. The pull output changes only while the clock line is low.
- R5: In the selection byte, bits [3:0] form the register pointer and bit 4 is the auto-advance flag. Bits [7:5] have no effect.
- R6: With the auto-advance flag at 0, every data byte up to the STOP is written to the selected register, so the last byte written remains.
- R7: With the auto-advance flag at 1, data bytes go to the pointer, then to pointer+1, and so on. The 4-bit pointer wraps from 15 to 0.
- R8: Data bytes aimed at pointer values 8 to 15 are acknowledged but change no register.
- R9: Data bits arrive MSB first. A register changes only after all 8 bits of its byte have been received, and only one register changes at a time. A byte cut short by a STOP leaves the registers unchanged.
- R10: A repeated START in the middle of a transfer restarts address matching. The new transfer's selection byte and data apply from then on, and registers written earlier keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| regs_o | output | 64 | Register bank, register k on bits [8k+7:8k] |

## Verification
The assertions assume the bus follows the two-wire rules. Data changes only while the clock is low, apart from START and STOP. Each clock-low phase must last longer than the synchronizer and state-register latency, so that the block's acknowledge and write activity finishes before the clock rises again. The bench drives the bus with a quarter-period of eight system clocks. It changes data only in the middle of the low phase and never stretches the clock. The open-drain line is modelled as the AND of the master's level and the inverted pull output.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_ACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_SEL,
        BK_DATA
    } kind_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] chain;
        logic [LINES-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [LINES-1:0] pins;
    logic [LINES-1:0] now;

    assign pins = {sda_i, scl_i};

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pins;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign now        = s_q.chain[STAGES-1];
    assign sda_o      = now[L_SDA];
    assign scl_rise_o = now[L_SCL] & ~s_q.prev[L_SCL];
    assign scl_fall_o = ~now[L_SCL] & s_q.prev[L_SCL];
    assign start_o    = now[L_SCL] & s_q.prev[L_SCL] & s_q.prev[L_SDA] & ~now[L_SDA];
    assign stop_o     = now[L_SCL] & s_q.prev[L_SCL] & ~s_q.prev[L_SDA] & now[L_SDA];

endmodule

// File: rtl/i2c_rb_proto.sv
module i2c_rb_proto
    import i2c_rb_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  DEV_ADDR = 7'b1000100,
    parameter int          PTR_W    = 4,
    parameter int          DATA_W   = 8,
    parameter int          INC_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    output logic              pull_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DATA_W);
    localparam logic [DATA_W-1:0] ADDR_WR  = DATA_W'({DEV_ADDR[ADDR_W-1:0], 1'b0});

    typedef struct packed {
        phase_e              phase;
        kind_e               kind;
        logic [DATA_W-1:0]   sh;
        logic [CNT_W-1:0]    cnt;
        logic [PTR_W-1:0]    ptr;
        logic                inc;
        logic                pull;
        logic                we;
        logic [PTR_W-1:0]    wptr;
        logic [DATA_W-1:0]   wdata;
    } st_t;

    st_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.we = 1'b0;
        if (start) begin
            p_d.phase = PH_SHIFT;
            p_d.kind  = BK_ADDR;
            p_d.cnt   = '0;
            p_d.pull  = 1'b0;
        end else if (stop) begin
            p_d.phase = PH_IDLE;
            p_d.pull  = 1'b0;
        end else begin
            unique case (p_q.phase)
                PH_SHIFT: begin
                    if (scl_rise && (p_q.cnt != FULL_CNT)) begin
                        p_d.sh  = {p_q.sh[DATA_W-2:0], sda_s};
                        p_d.cnt = p_q.cnt + 1'b1;
                    end else if (scl_fall && (p_q.cnt == FULL_CNT)) begin
                        p_d.cnt   = '0;
                        p_d.phase = PH_ACK;
                        p_d.pull  = 1'b1;
                        unique case (p_q.kind)
                            BK_ADDR: begin
                                if (p_q.sh == ADDR_WR) begin
                                    p_d.kind = BK_SEL;
                                end else begin
                                    p_d.phase = PH_SKIP;
                                    p_d.pull  = 1'b0;
                                end
                            end
                            BK_SEL: begin
                                p_d.ptr  = p_q.sh[PTR_W-1:0];
                                p_d.inc  = p_q.sh[INC_BIT];
                                p_d.kind = BK_DATA;
                            end
                            default: begin
                                p_d.we    = 1'b1;
                                p_d.wptr  = p_q.ptr;
                                p_d.wdata = p_q.sh;
                                if (p_q.inc) begin
                                    p_d.ptr = p_q.ptr + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        p_d.pull  = 1'b0;
                        p_d.phase = PH_SHIFT;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q       <= '0;
            p_q.phase <= PH_IDLE;
            p_q.kind  <= BK_ADDR;
        end else begin
            p_q <= p_d;
        end
    end

    assign pull_o    = p_q.pull;
    assign wr_en_o   = p_q.we;
    assign wr_ptr_o  = p_q.wptr;
    assign wr_data_o = p_q.wdata;

endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    parameter int PTR_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] r_d, r_q;
        logic              hit;

        assign hit = wr_en && (wr_ptr == PTR_W'(g));

        always_comb begin
            r_d = r_q;
            if (hit) begin
                r_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_o[g*DATA_W +: DATA_W] = r_q;
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter int         NUM_REGS    = 8,
    parameter int         DATA_W      = 8,
    parameter int         PTR_W       = 4,
    parameter int         INC_BIT     = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1000100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic              sda_s;
    logic              scl_rise_w;
    logic              scl_fall_w;
    logic              start_w;
    logic              stop_w;
    logic              wr_en_w;
    logic [PTR_W-1:0]  wr_ptr_w;
    logic [DATA_W-1:0] wr_data_w;

    i2c_rb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_rb_proto #(
        .ADDR_W   (7),
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W),
        .DATA_W   (DATA_W),
        .INC_BIT  (INC_BIT)
    ) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start     (start_w),
        .stop      (stop_w),
        .pull_o    (sda_pull_o),
        .wr_en_o   (wr_en_w),
        .wr_ptr_o  (wr_ptr_w),
        .wr_data_o (wr_data_w)
    );

    i2c_rb_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .PTR_W    (PTR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_ptr  (wr_ptr_w),
        .wr_data (wr_data_w),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_i,
    input logic                       sda_pull_o,
    input logic [NUM_REGS*DATA_W-1:0] regs_o,
    input logic                       start_det,
    input logic                       stop_det
);
    logic [NUM_REGS*DATA_W-1:0] seen_q;
    logic [NUM_REGS-1:0]        chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= regs_o;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
        assign chg[g] = regs_o[g*DATA_W +: DATA_W] != seen_q[g*DATA_W +: DATA_W];
    end

    assert_one_reg_per_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    assert_write_while_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |-> !scl_i);

    assert_ack_assert_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    assert_ack_release_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_i);

    assert_release_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    assert_release_after_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o);

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .regs_o     (regs_o),
    .start_det  (start_w),
    .stop_det   (stop_w)
);

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
    localparam int Q     = 8;
    localparam int NREG  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        pull;
    logic [63:0] regs;
    wire         sda_line;

    assign sda_line = msda & ~pull;

    always #5 clk = ~clk;

    i2c_regbank_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .regs_o     (regs)
    );

    int         checks = 0;
    int         errors = 0;
    bit         running = 1'b0;
    bit         done = 1'b0;
    logic [7:0] mreg [NREG];
    int         mstate = 0;
    logic [3:0] mptr = '0;
    logic       minc = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Reference model: state 0 idle, 1 address, 2 select, 3 data, 4 ignore
    task automatic model_byte(input logic [7:0] b, output bit ack);
        ack = 1'b0;
        case (mstate)
            1: begin
                if (b == 8'h88) begin ack = 1'b1; mstate = 2; end
                else mstate = 4;
            end
            2: begin
                mptr = b[3:0]; minc = b[4]; mstate = 3; ack = 1'b1;
            end
            3: begin
                if (mptr < 4'd8) mreg[mptr] = b;
                if (minc) mptr = mptr + 4'd1;
                ack = 1'b1;
            end
            default: ack = 1'b0;
        endcase
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mreg[i];
        return f;
    endfunction

    // Per-clock comparison while the bus clock is high (R9 timing window)
    always @(negedge clk) begin
        if (running && scl) begin
            check(regs == model_flat(), "R9", "per-clock register model", regs, model_flat());
        end
    end

    task automatic bus_start();
        msda = 1'b1; wclk(Q);
        scl = 1'b1;  wclk(Q);
        msda = 1'b0; mstate = 1; wclk(Q);
        scl = 1'b0;  wclk(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wclk(Q);
        scl = 1'b1;  wclk(Q);
        msda = 1'b1; mstate = 0; wclk(Q);
    endtask

    task automatic send_bit(input logic b);
        msda = b;   wclk(Q);
        scl = 1'b1; wclk(2*Q);
        scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        bit ack;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        msda = 1'b1; wclk(Q);
        scl = 1'b1;
        model_byte(b, ack);
        wclk(Q);
        @(negedge clk);
        check(sda_line == !ack, req, "ack level on ninth clock", 64'(sda_line), 64'(!ack));
        wclk(Q);
        scl = 1'b0; wclk(Q);
    endtask

    task automatic expect_reg(input int idx, input logic [7:0] val, input string req);
        @(negedge clk);
        check(regs[idx*8 +: 8] == val, req, $sformatf("register %0d", idx),
              64'(regs[idx*8 +: 8]), 64'(val));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        wclk(3);
        @(negedge clk);
        check(regs == 64'h0, "R1", "registers after reset", regs, 64'h0);
        check(pull == 1'b0, "R1", "pull after reset", 64'(pull), 64'h0);
        rst_n = 1'b1;
        wclk(4);
        running = 1'b1;

        // R5, R6: fixed pointer 3, don't-care upper bits set
        bus_start();
        send_byte(8'h88, "R3");
        send_byte(8'hE3, "R5");
        send_byte(8'hA5, "R6");
        send_byte(8'h5A, "R6");
        send_byte(8'h3C, "R6");
        bus_stop();
        expect_reg(3, 8'h3C, "R6");
        expect_reg(2, 8'h00, "R5");
        expect_reg(4, 8'h00, "R5");

        // R7: auto-advance from 5
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h15, "R4");
        send_byte(8'h11, "R7");
        send_byte(8'h22, "R7");
        send_byte(8'h33, "R7");
        bus_stop();
        expect_reg(5, 8'h11, "R7");
        expect_reg(6, 8'h22, "R7");
        expect_reg(7, 8'h33, "R7");

        // R7 wrap and R8 dropped writes: start at 14
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h1E, "R4");
        send_byte(8'h44, "R8");
        send_byte(8'h55, "R8");
        send_byte(8'h66, "R7");
        send_byte(8'h77, "R7");
        bus_stop();
        expect_reg(0, 8'h66, "R7");
        expect_reg(1, 8'h77, "R7");
        expect_reg(7, 8'h33, "R8");

        // R8: fixed pointer 9
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h09, "R4");
        send_byte(8'h99, "R8");
        send_byte(8'hAA, "R8");
        bus_stop();
        expect_reg(1, 8'h77, "R8");
        check(regs == model_flat(), "R8", "bank after out-of-range writes", regs, model_flat());

        // R3: wrong address and read direction
        bus_start();
        send_byte(8'h8A, "R3");
        send_byte(8'h00, "R3");
        send_byte(8'hFF, "R3");
        bus_stop();
        bus_start();
        send_byte(8'h89, "R3");
        send_byte(8'h00, "R3");
        send_byte(8'h12, "R3");
        bus_stop();
        expect_reg(0, 8'h66, "R3");

        // R9: MSB first, and truncated byte
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h04, "R4");
        send_byte(8'hC1, "R9");
        bus_stop();
        expect_reg(4, 8'hC1, "R9");
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h02, "R4");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        expect_reg(2, 8'h00, "R9");

        // R2: bytes clocked after STOP without START
        scl = 1'b0; wclk(Q);
        send_byte(8'h88, "R2");
        send_byte(8'h00, "R2");
        send_byte(8'h5F, "R2");
        msda = 1'b1; wclk(Q);
        scl = 1'b1; wclk(2*Q);
        expect_reg(0, 8'h66, "R2");

        // R10: repeated START in the middle
        bus_start();
        send_byte(8'h88, "R4");
        send_byte(8'h00, "R4");
        send_byte(8'hAB, "R10");
        bus_start();
        send_byte(8'h88, "R10");
        send_byte(8'h07, "R10");
        send_byte(8'hCD, "R10");
        bus_stop();
        expect_reg(0, 8'hAB, "R10");
        expect_reg(7, 8'hCD, "R10");
        @(negedge clk);
        check(pull == 1'b0, "R2", "pull idle after stop", 64'(pull), 64'h0);

        running = 1'b0;
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule